// File: doc/BRIEF.md
# DMA Segment Length Limiter

This block takes a bus address and the length a transfer wants, and returns the largest length that a DMA engine can move in one segment. Two limits apply, in a fixed order. First the length is held to what the transfer counter can count: 2^16 bytes when the wide-counter mode is off and 2^24 bytes when it is on. Then the segment is kept from crossing a 16 MiB address window. The low 24 bits of the address give the offset inside that window, and the length is cut so that offset plus length never goes past 2^24.

The block takes a request as an address, a length and a mode, all qualified by a valid strobe. It returns the clipped length with its own valid strobe one cycle later. The output is 25 bits wide, so it can hold exactly 2^24. A new request can be accepted on every cycle. Splitting a transfer into segments, and the transfers themselves, belong to the caller.

Top module: `dma_seg_clip`

## Requirements
- R1: After reset, `res_valid` is 0 and `res_len` is 0.
- R2: `res_valid` is asserted exactly one cycle after `req_valid`, and is low otherwise.
- R3: With `req_wide`=0 the counter limit is 2^16. With `req_wide`=1 it is 2^24.
- R4: A requested length above the counter limit is reduced to exactly that limit. A length at or below the limit is passed to the next stage unchanged.
- R5: With base = `req_addr[23:0]`: when base plus the width-limited length exceeds 2^24, the result is 2^24 minus base. Otherwise the result is the width-limited length.
- R6: The width limit is applied first and the window limit second, so the result is min(min(len, limit), 2^24 - base).
- R7: A requested length of zero yields a result of zero.
- R8: `req_addr[31:24]` has no effect on the result.
- R9: `res_len` holds its value while `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Segment start bus address |
| req_len | input | 32 | Requested length in bytes |
| req_wide | input | 1 | 1 selects the 24-bit counter, 0 selects the 16-bit counter |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_len | output | 25 | Clipped length |

## Verification
Assertions check these properties on every cycle:
- the one-cycle valid timing;
- the result never exceeding the counter limit for the mode of the previous cycle;
- the result never reaching past the window end;
- zero mapping to zero;
- the result holding while idle.

Some behaviour only the directed scenarios show:
- the exact value at each boundary (limit minus one, the limit, limit plus one);
- an offset at the very end of the window;
- the interplay when both limits bind;
- that the upper address bits are ignored.

// File: rtl/dma_seg_clip_pkg.sv
package dma_seg_clip_pkg;
  localparam int ADDR_W   = 32;
  localparam int LEN_W    = 32;
  localparam int WIN_W    = 24;
  localparam int NARROW_W = 16;
  localparam int OUT_W    = WIN_W + 1;

  typedef enum logic { CNT_NARROW = 1'b0, CNT_WIDE = 1'b1 } cnt_mode_e;
endpackage

// File: rtl/dma_width_limit.sv
module dma_width_limit #(
  parameter int LEN_W    = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 24,
  localparam int OUT_W   = WIDE_W + 1
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             wide_i,
  output logic [OUT_W-1:0] len_o
);
  localparam logic [LEN_W-1:0] NARROW_MAX = LEN_W'(1) << NARROW_W;
  localparam logic [LEN_W-1:0] WIDE_MAX   = LEN_W'(1) << WIDE_W;

  logic [LEN_W-1:0] cap;
  always_comb begin
    cap   = wide_i ? WIDE_MAX : NARROW_MAX;
    len_o = (len_i > cap) ? OUT_W'(cap) : OUT_W'(len_i);
  end
endmodule

// File: rtl/dma_window_limit.sv
module dma_window_limit #(
  parameter int ADDR_W = 32,
  parameter int WIN_W  = 24,
  localparam int OUT_W = WIN_W + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [OUT_W-1:0]  len_i,
  output logic [OUT_W-1:0]  len_o
);
  localparam logic [OUT_W:0] WIN_END = (OUT_W+1)'(1) << WIN_W;

  logic [WIN_W-1:0] base;
  logic [OUT_W:0]   room;
  logic [OUT_W:0]   reach;
  always_comb begin
    base  = addr_i[WIN_W-1:0];
    room  = WIN_END - (OUT_W+1)'(base);
    reach = (OUT_W+1)'(base) + (OUT_W+1)'(len_i);
    len_o = (reach > WIN_END) ? room[OUT_W-1:0] : len_i;
  end
endmodule

// File: rtl/dma_seg_clip.sv
module dma_seg_clip
  import dma_seg_clip_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_wide,
  output logic              res_valid,
  output logic [OUT_W-1:0]  res_len
);
  logic [OUT_W-1:0] w_len;
  logic [OUT_W-1:0] c_len;

  dma_width_limit #(.LEN_W(LEN_W), .NARROW_W(NARROW_W), .WIDE_W(WIN_W)) u_width (
    .len_i(req_len), .wide_i(req_wide), .len_o(w_len));

  dma_window_limit #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_window (
    .addr_i(req_addr), .len_i(w_len), .len_o(c_len));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_len   <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) res_len <= c_len;
    end
  end

  localparam logic [OUT_W-1:0] WIN_SZ = OUT_W'(1) << WIN_W;
  localparam logic [OUT_W-1:0] NAR_SZ = OUT_W'(1) << NARROW_W;

  assert_valid_timing_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
  assert_narrow_cap_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_wide) |=> res_len <= NAR_SZ);
  assert_window_end_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> ((OUT_W+1)'(res_len) + (OUT_W+1)'($past(req_addr[WIN_W-1:0]))) <= (OUT_W+1)'(WIN_SZ));
  assert_zero_len_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_len == '0) |=> res_len == '0);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(res_len));
endmodule

// File: tb/dma_seg_clip_tb_top.sv
module dma_seg_clip_tb_top;
  logic clk = 0, rst = 1, req_valid = 0, req_wide = 0;
  logic [31:0] req_addr = 0, req_len = 0;
  logic res_valid;
  logic [24:0] res_len;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  dma_seg_clip dut_i (.clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_wide(req_wide), .res_valid(res_valid), .res_len(res_len));

  function automatic logic [24:0] model(input logic [31:0] a, input logic [31:0] l, input logic w);
    longint cap, v, room;
    cap  = w ? (64'd1 << 24) : (64'd1 << 16);
    v    = (l > cap) ? cap : l;
    room = (64'd1 << 24) - a[23:0];
    if (v > room) v = room;
    return v[24:0];
  endfunction

  task automatic chk(input string r, input logic [24:0] act, input logic [24:0] exp);
    total++;
    if (act !== exp) begin bad++; $display("FAIL %s act=%0h exp=%0h", r, act, exp); end
  endtask

  task automatic one(input string r, input logic [31:0] a, input logic [31:0] l, input logic w);
    @(negedge clk); req_valid = 1; req_addr = a; req_len = l; req_wide = w;
    @(negedge clk); req_valid = 0;
    chk({r, " valid"}, {24'd0, res_valid}, 25'd1);
    chk(r, res_len, model(a, l, w));
  endtask

  task automatic t_reset();
    chk("R1 valid", {24'd0, res_valid}, 0);
    chk("R1 len", res_len, 0);
  endtask

  task automatic t_narrow();
    one("R3 narrow small", 32'h0, 32'h1234, 0);
    one("R4 narrow at cap", 32'h0, 32'h10000, 0);
    one("R4 narrow over", 32'h0, 32'h10001, 0);
    one("R3 narrow huge", 32'h100, 32'hFFFF_FFFF, 0);
  endtask

  task automatic t_wide();
    one("R3 wide mid", 32'h0, 32'h20000, 1);
    one("R4 wide at cap", 32'h0, 32'h100_0000, 1);
    one("R4 wide over", 32'h0, 32'h100_0001, 1);
  endtask

  task automatic t_window();
    one("R5 last byte", 32'h00FF_FFFF, 32'h100, 1);
    one("R5 exact fit", 32'h00FF_0000, 32'h10000, 0);
    one("R5 cross", 32'h00FF_8000, 32'h10000, 0);
    one("R6 both bind", 32'h0080_0000, 32'hFFFF_FFFF, 1);
    chk("R6 both value", res_len, 25'h80_0000);
  endtask

  task automatic t_zero_upper();
    one("R7 zero", 32'h00FF_FFFF, 32'h0, 1);
    one("R8 upper bits", 32'hAB00_1000, 32'h10000, 0);
    chk("R8 upper value", res_len, 25'h10000);
  endtask

  task automatic t_back2back();
    logic [24:0] held;
    @(negedge clk); req_valid = 1; req_addr = 0; req_len = 32'h5; req_wide = 0;
    @(negedge clk); req_addr = 32'h00FF_FFF0; req_len = 32'h100; req_wide = 1;
    chk("R2 b2b first", res_len, 25'h5);
    @(negedge clk); req_valid = 0; req_len = 32'h77;
    chk("R2 b2b second", res_len, 25'h10);
    held = res_len;
    @(negedge clk);
    chk("R2 idle valid", {24'd0, res_valid}, 0);
    @(negedge clk);
    chk("R9 hold", res_len, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_narrow(); t_wide(); t_window(); t_zero_upper(); t_back2back();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog act=hang exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule